// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM device from power-up to normal operation. After a start pulse it walks a fixed list of initialization steps. Each of the first three kinds of step waits for one access to the SDRAM address space and turns that access into a device command. The steps are precharge of all banks, then eight auto-refresh commands, then a mode-register load. Each issued command appears on a command bus with a one-cycle strobe. After each command the block pauses for a programmable number of idle cycles before it accepts the next access, which covers recovery times such as row precharge and refresh cycle time.

When the mode-register load and its pause are finished, the block issues a normal-mode command by itself. It then drops busy, raises ready and starts periodic refresh. Refresh requests come from two counters in series. A prescaler divides the clock by a programmable value, and a refresh timer counts a programmable number of those ticks between requests. The sequence runs once per reset.

Top module: `sdram_init_seq`

## Requirements
- R1: During and after reset, `cmd` is NOP (code 0), and `cmd_stb`, `busy`, `ready` and `refresh_req` are all low.
- R2: A `start` pulse while the block is idle raises `busy` on the next cycle. Accesses seen before `start` produce no command.
- R3: After `start`, the first access issues precharge-all (code 1) on `cmd`, with `cmd_stb` high for exactly one cycle.
- R4: The next eight accepted accesses each issue auto-refresh (code 2), one command per access.
- R5: The access after the eighth refresh issues load-mode (code 3).
- R6: After a command is strobed with an idle count of W, accesses sampled in the following W+1 cycles produce no command and do not advance the sequence.
- R7: When the pause after load-mode ends, the block strobes normal-mode (code 4) without any access. In the same cycle `busy` falls and `ready` rises, and `ready` then stays high until reset.
- R8: A `start` pulse while `busy` is high is ignored, and the sequence keeps its position.
- R9: Once `ready` is high, `refresh_req` pulses high for one cycle every P*T cycles, where P is `prescale` and T is `ref_period` (both at least 1). `refresh_req` never rises while `ready` is low.
- R10: Accesses after `ready` is high produce no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the initialization sequence |
| sdram_access | input | 1 | One-cycle strobe for an access to the SDRAM space |
| step_wait | input | WAIT_W | Idle cycles W after each command |
| prescale | input | PRE_W | Clock divider P for refresh ticks |
| ref_period | input | TMR_W | Ticks T between refresh requests |
| cmd | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 load-mode, 4 normal |
| cmd_stb | output | 1 | One-cycle strobe marking a valid command |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Initialization complete, sticky until reset |
| refresh_req | output | 1 | Periodic refresh request pulse |

## Verification
Some properties are checked on every cycle by assertions. A strobe never carries NOP. `busy` and `ready` are never high together, and `ready` stays high once set. Load-mode is strobed only after exactly eight refreshes. A refresh request appears only while refresh is enabled. Other behaviour only the bench scenarios can show. These are the exact order of command codes, the ignored accesses during a pause, the ignored start while busy, and the spacing of refresh requests for two prescaler and timer settings.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PREALL = 3'd1,
    CMD_AREF   = 3'd2,
    CMD_LMODE  = 3'd3,
    CMD_NORMAL = 3'd4
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREALL,
    ST_AREF,
    ST_LMODE,
    ST_PAUSE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int WAIT_W    = 8,
  parameter int REF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sdram_access,
  input  logic [WAIT_W-1:0] step_wait,
  output logic [2:0]        cmd,
  output logic              cmd_stb,
  output logic              busy,
  output logic              ready
);
  localparam int RC_W = $clog2(REF_COUNT + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(REF_COUNT - 1);

  seq_state_e        state, resume;
  logic [WAIT_W-1:0] pause_cnt;
  logic [RC_W-1:0]   aref_cnt;
  sd_cmd_e           cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      resume    <= ST_IDLE;
      pause_cnt <= '0;
      aref_cnt  <= '0;
      cmd_q     <= CMD_NOP;
      cmd_stb   <= 1'b0;
      busy      <= 1'b0;
      ready     <= 1'b0;
    end else begin
      cmd_q   <= CMD_NOP;
      cmd_stb <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_PREALL;
          busy  <= 1'b1;
        end
        ST_PREALL: if (sdram_access) begin
          cmd_q     <= CMD_PREALL;
          cmd_stb   <= 1'b1;
          resume    <= ST_AREF;
          pause_cnt <= step_wait;
          state     <= ST_PAUSE;
        end
        ST_AREF: if (sdram_access) begin
          cmd_q     <= CMD_AREF;
          cmd_stb   <= 1'b1;
          aref_cnt  <= aref_cnt + 1'b1;
          resume    <= (aref_cnt == RC_LAST) ? ST_LMODE : ST_AREF;
          pause_cnt <= step_wait;
          state     <= ST_PAUSE;
        end
        ST_LMODE: if (sdram_access) begin
          cmd_q     <= CMD_LMODE;
          cmd_stb   <= 1'b1;
          resume    <= ST_DONE;
          pause_cnt <= step_wait;
          state     <= ST_PAUSE;
        end
        ST_PAUSE: begin
          if (pause_cnt == '0) begin
            state <= resume;
            if (resume == ST_DONE) begin
              cmd_q   <= CMD_NORMAL;
              cmd_stb <= 1'b1;
              busy    <= 1'b0;
              ready   <= 1'b1;
            end
          end else begin
            pause_cnt <= pause_cnt - 1'b1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign cmd = cmd_q;

  // R3
  stb_not_nop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> cmd != CMD_NOP);
  // R7
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && ready));
  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  // R5
  lmode_after_refs_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd == CMD_LMODE) |-> aref_cnt == RC_W'(REF_COUNT));
  // R8
  start_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(state == ST_PAUSE && resume == ST_DONE)) |=> busy);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int PRE_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PRE_W-1:0] prescale,
  input  logic [TMR_W-1:0] ref_period,
  output logic             refresh_req
);
  logic [PRE_W-1:0] pre_cnt;
  logic [TMR_W-1:0] tick_cnt;
  logic             tick;

  assign tick = (pre_cnt == prescale - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pre_cnt     <= '0;
      tick_cnt    <= '0;
      refresh_req <= 1'b0;
    end else begin
      refresh_req <= 1'b0;
      if (tick) begin
        pre_cnt <= '0;
        if (tick_cnt == ref_period - 1'b1) begin
          tick_cnt    <= '0;
          refresh_req <= 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R9
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_req) |-> $past(enable));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int WAIT_W    = 8,
  parameter int PRE_W     = 8,
  parameter int TMR_W     = 8,
  parameter int REF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sdram_access,
  input  logic [WAIT_W-1:0] step_wait,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [TMR_W-1:0]  ref_period,
  output logic [2:0]        cmd,
  output logic              cmd_stb,
  output logic              busy,
  output logic              ready,
  output logic              refresh_req
);
  sdram_init_fsm #(.WAIT_W(WAIT_W), .REF_COUNT(REF_COUNT)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .sdram_access(sdram_access),
    .step_wait(step_wait), .cmd(cmd), .cmd_stb(cmd_stb),
    .busy(busy), .ready(ready)
  );

  sdram_refresh_timer #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_refresh (
    .clk(clk), .rst(rst), .enable(ready), .prescale(prescale),
    .ref_period(ref_period), .refresh_req(refresh_req)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ready) |-> !refresh_req);
endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       sdram_access = 1'b0;
  logic [7:0] step_wait = 8'd3;
  logic [7:0] prescale = 8'd3;
  logic [7:0] ref_period = 8'd4;
  logic [2:0] cmd;
  logic       cmd_stb, busy, ready, refresh_req;

  int checks = 0;
  int errors = 0;
  int early_req = 0;

  localparam int NSTEP = 10;
  localparam logic [2:0] EXP_CMD [NSTEP] = '{3'd1, 3'd2, 3'd2, 3'd2, 3'd2,
                                             3'd2, 3'd2, 3'd2, 3'd2, 3'd3};

  always #10 clk = ~clk;

  sdram_init_seq u_sdram_init_seq (
    .clk(clk), .rst(rst), .start(start), .sdram_access(sdram_access),
    .step_wait(step_wait), .prescale(prescale), .ref_period(ref_period),
    .cmd(cmd), .cmd_stb(cmd_stb), .busy(busy), .ready(ready),
    .refresh_req(refresh_req)
  );

  always @(negedge clk) if (!rst && !ready && refresh_req) early_req++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_access();
    sdram_access = 1'b1;
    @(negedge clk);
    sdram_access = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < int'(step_wait) + 2; i++) @(negedge clk);
  endtask

  task automatic run_sequence(input string tag);
    for (int i = 0; i < NSTEP; i++) begin
      pulse_access();
      check(cmd_stb && cmd == EXP_CMD[i], tag, {cmd_stb, cmd}, {1'b1, EXP_CMD[i]});
      settle();
    end
  endtask

  task automatic measure_period(input int exp, input string tag);
    int n = 0;
    int gap = 0;
    while (!refresh_req && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); gap = 1;
    while (!refresh_req && gap < 2000) begin @(negedge clk); gap++; end
    check(gap == exp, tag, gap, exp);
    @(negedge clk);
    check(!refresh_req || exp == 1, {tag, " one-cycle pulse"}, refresh_req, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd == 3'd0 && !cmd_stb && !busy && !ready && !refresh_req, "R1",
          {cmd_stb, busy, ready, refresh_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2: access before start is not a command
    pulse_access();
    check(!cmd_stb && !busy, "R2 access before start", cmd_stb, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy, "R2 busy after start", busy, 1);

    // R3: first step, precharge-all
    pulse_access();
    check(cmd_stb && cmd == 3'd1, "R3", cmd, 1);
    // R6: access during pause ignored
    pulse_access();
    check(!cmd_stb, "R6 access in pause", cmd_stb, 0);
    @(negedge clk);
    check(!cmd_stb, "R3 strobe one cycle", cmd_stb, 0);
    // R8: start while busy ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    settle();
    check(busy && !ready, "R8 still busy", busy, 1);

    // R4, R5: walk the table of remaining steps
    for (int i = 1; i < NSTEP; i++) begin
      pulse_access();
      check(cmd_stb && cmd == EXP_CMD[i], i < NSTEP - 1 ? "R4 refresh step" : "R5 load-mode",
            cmd, EXP_CMD[i]);
      settle();
    end
    // R7: normal mode issued without access (pause W+1 after load-mode)
    check(ready && !busy, "R7 ready after normal", ready, 1);
    // R10: access after ready gives nothing
    pulse_access();
    check(!cmd_stb, "R10 access after ready", cmd_stb, 0);
    // R9: refresh spacing P*T = 12
    measure_period(12, "R9 period 3x4");
    check(ready, "R7 ready sticky", ready, 1);

    // second run: no pause, P=2,T=3
    rst = 1'b1; step_wait = 8'd0; prescale = 8'd2; ref_period = 8'd3;
    repeat (2) @(negedge clk);
    check(!ready && !busy && cmd == 3'd0, "R1 reset clears ready", ready, 0);
    rst = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    run_sequence("R4 R5 zero-wait sequence");
    // pause 0: normal strobe at first edge after load-mode cycle
    check(ready, "R7 zero-wait ready", ready, 1);
    measure_period(6, "R9 period 2x3");
    check(early_req == 0, "R9 no request before ready", early_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule